// File: doc/BRIEF.md
# Triggered Scan Acquisition Sequencer

This block decides which completed multi-channel scans are kept in the sample buffer, relative to a trigger event. An external scan engine reports each finished scan with a one-cycle strobe and holds a busy flag while a scan runs. The sequencer grants permission to start new conversions, marks each scan that goes into the buffer, and raises a done flag when the acquisition is over. The buffer itself is represented only by a count of the scans it holds.

Four trigger placements are selected by a two-bit mode. In pre-trigger mode (0), scans are stored before the trigger and the newest M are kept. In middle-trigger mode (1), the newest M scans before the trigger are kept and then N scans after it. In post-trigger mode (2), conversions wait for the trigger and then N scans are stored. In delay-trigger mode (3), the sequencer waits a programmed number of clock cycles after the trigger and then stores N scans. Post and delay modes can re-arm after each burst for a programmed number of trigger events, or without limit. An optional guard makes the sequencer ignore triggers until M scans have been taken. A start pulse launches an acquisition from idle or done. An abort pulse returns the sequencer to idle.

Top module: `scan_acq_seq`

## Requirements
- R1: After reset the sequencer is idle: convEn, storeEn and acqDone are low, and storedCount, postCount and trigCount are 0.
- R2: In mode 0, every scan completed after start is stored. An accepted trigger drops convEn at once, and the scan in progress still completes and is stored. acqDone then rises and storedCount equals min(scans completed, mCount), so an early trigger leaves fewer than mCount scans.
- R3: With mGuard set in mode 0 or 1, a trigger that arrives while fewer than mCount scans have completed is ignored and is not counted in trigCount.
- R4: In mode 0, postCount stays at 0 for the whole acquisition.
- R5: In mode 1, exactly nCount scans are stored after the accepted trigger, counting the scan in progress at the trigger. acqDone then rises, with storedCount = min(scans before the trigger, mCount) + nCount.
- R6: In mode 2, convEn stays low until a trigger is sampled and rises on the next clock. nCount scans are then stored per trigger event.
- R7: In mode 3, convEn rises delayCount clock cycles later than it would in mode 2. With delayCount = 0, the timing is identical to mode 2.
- R8: In modes 2 and 3 with retrigLimit non-zero, acqDone rises after retrigLimit bursts and trigCount equals retrigLimit. With retrigLimit = 0, the sequencer re-arms without end and acqDone never rises.
- R9: storeEn is a one-cycle pulse in the cycle after each stored scan's scanDone. Every scan completed while conversions were enabled is stored. storedCount never steps by more than one per cycle.
- R10: An abortReq sampled on a clock edge leaves the sequencer idle after that edge. storeEn, convEn and acqDone are then low, even if scanDone was sampled on the same edge, and that scan is not counted. Triggers are ignored in idle.
- R11: In modes 2 and 3, a trigger that arrives during the delay wait or while a burst is being collected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, accepted in idle or done |
| abortReq | input | 1 | Software abort pulse |
| modeSel | input | 2 | 0 pre, 1 middle, 2 post, 3 delay |
| mGuard | input | 1 | Ignore triggers until mCount scans are taken |
| mCount | input | CNT_W | Scans kept before the trigger |
| nCount | input | CNT_W | Scans stored after each trigger |
| delayCount | input | DLY_W | Clock cycles waited after a trigger in mode 3 |
| retrigLimit | input | CNT_W | Number of trigger bursts, 0 means unlimited |
| scanDone | input | 1 | One-cycle strobe at the end of a scan |
| convBusy | input | 1 | A scan is in progress |
| trigIn | input | 1 | Trigger event |
| storeEn | output | 1 | The scan that just completed is written to the buffer |
| convEn | output | 1 | New scans may be started |
| acqDone | output | 1 | Acquisition finished |
| storedCount | output | CNT_W+1 | Scans held in the buffer |
| postCount | output | CNT_W+1 | Scans stored since the last accepted trigger |
| trigCount | output | CNT_W+1 | Triggers accepted in this acquisition |

## Verification
Two events can fall on the same clock edge: a software abort, and the completion of a scan that would otherwise be stored. The bench provokes this by raising abortReq in the very cycle its scan model pulses scanDone. It then checks that storeEn stays low on the following cycle and that storedCount keeps its previous value, so the abort wins. A second coincidence is tested in pre-trigger mode. The trigger lands while a scan is busy, and the bench expects that scan to be stored before acqDone rises.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    ACQ_PRE   = 2'd0,
    ACQ_MID   = 2'd1,
    ACQ_POST  = 2'd2,
    ACQ_DELAY = 2'd3
  } acqMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_MIDPOST,
    ST_WAIT,
    ST_DELAY,
    ST_COLLECT,
    ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic clrPost;
    logic incFill;
    logic incPost;
    logic incStored;
    logic incTrig;
    logic loadDly;
    logic decDly;
  } seqStrobe_t;

endpackage

// File: rtl/scan_seq_ctr.sv
module scan_seq_ctr #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (inc && (value != '1)) begin
      value <= value + 1'b1;
    end
  end

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [CNT_W-1:0] mCount,
  input  logic [CNT_W-1:0] nCount,
  input  logic [DLY_W-1:0] delayCount,
  input  logic [CNT_W-1:0] retrigLimit,
  output logic             fillFull,
  output logic             postLast,
  output logic             dlyLast,
  output logic             dlyZero,
  output logic             trigExhausted,
  output logic [CNT_W:0]   storedCount,
  output logic [CNT_W:0]   postCount,
  output logic [CNT_W:0]   trigCount
);

  localparam int CW        = CNT_W + 1;
  localparam int NUM_CTR   = 4;
  localparam int IDX_FILL  = 0;
  localparam int IDX_POST  = 1;
  localparam int IDX_STORE = 2;
  localparam int IDX_TRIG  = 3;

  logic [NUM_CTR-1:0] clrVec;
  logic [NUM_CTR-1:0] incVec;
  logic [CW-1:0]      cntVal [NUM_CTR];
  logic [DLY_W-1:0]   dlyCnt;
  logic [CW:0]        postNext;

  assign clrVec[IDX_FILL]  = stb.clrAll;
  assign clrVec[IDX_POST]  = stb.clrAll | stb.clrPost;
  assign clrVec[IDX_STORE] = stb.clrAll;
  assign clrVec[IDX_TRIG]  = stb.clrAll;

  assign incVec[IDX_FILL]  = stb.incFill;
  assign incVec[IDX_POST]  = stb.incPost;
  assign incVec[IDX_STORE] = stb.incStored;
  assign incVec[IDX_TRIG]  = stb.incTrig;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    scan_seq_ctr #(.W(CW)) ctrInst (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (clrVec[g]),
      .inc   (incVec[g]),
      .value (cntVal[g])
    );
  end

  // delay wait counter, counts timebase cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (stb.clrAll) begin
      dlyCnt <= '0;
    end else if (stb.loadDly) begin
      dlyCnt <= delayCount;
    end else if (stb.decDly && (dlyCnt != '0)) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign postNext      = {1'b0, cntVal[IDX_POST]} + 1'b1;
  assign fillFull      = cntVal[IDX_FILL] >= {1'b0, mCount};
  assign postLast      = postNext >= {2'b00, nCount};
  assign dlyLast       = dlyCnt <= DLY_W'(1);
  assign dlyZero       = delayCount == '0;
  assign trigExhausted = (retrigLimit != '0) && (cntVal[IDX_TRIG] >= {1'b0, retrigLimit});

  assign storedCount = cntVal[IDX_STORE];
  assign postCount   = cntVal[IDX_POST];
  assign trigCount   = cntVal[IDX_TRIG];

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       abortReq,
  input  acqMode_e   mode,
  input  logic       mGuard,
  input  logic       scanDone,
  input  logic       convBusy,
  input  logic       trigIn,
  input  logic       fillFull,
  input  logic       postLast,
  input  logic       dlyLast,
  input  logic       dlyZero,
  input  logic       trigExhausted,
  output seqStrobe_t stb,
  output logic       storeEn,
  output logic       convEn,
  output logic       acqDone
);

  seqState_e state;
  seqState_e stateNxt;
  logic      storeNow;
  logic      storeQ;
  logic      trigOk;
  logic      preModes;

  assign preModes = (mode == ACQ_PRE) || (mode == ACQ_MID);
  assign trigOk   = trigIn && (!mGuard || fillFull);

  always_comb begin
    stateNxt = state;
    stb      = '0;
    storeNow = 1'b0;
    if (abortReq) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (startReq) begin
            stb.clrAll = 1'b1;
            stateNxt   = preModes ? ST_FILL : ST_WAIT;
          end
        end
        ST_FILL: begin
          if (scanDone) begin
            storeNow      = 1'b1;
            stb.incFill   = 1'b1;
            stb.incStored = !fillFull;
          end
          if (trigOk) begin
            stb.incTrig = 1'b1;
            stateNxt    = (mode == ACQ_MID) ? ST_MIDPOST : ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (scanDone) begin
            storeNow      = 1'b1;
            stb.incFill   = 1'b1;
            stb.incStored = !fillFull;
          end
          if (!convBusy) begin
            stateNxt = ST_DONE;
          end
        end
        ST_MIDPOST, ST_COLLECT: begin
          if (scanDone) begin
            storeNow      = 1'b1;
            stb.incPost   = 1'b1;
            stb.incStored = 1'b1;
            if (postLast) begin
              stateNxt = ((state == ST_MIDPOST) || trigExhausted) ? ST_DONE : ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (trigIn) begin
            stb.incTrig = 1'b1;
            stb.clrPost = 1'b1;
            if ((mode == ACQ_DELAY) && !dlyZero) begin
              stb.loadDly = 1'b1;
              stateNxt    = ST_DELAY;
            end else begin
              stateNxt = ST_COLLECT;
            end
          end
        end
        ST_DELAY: begin
          stb.decDly = 1'b1;
          if (dlyLast) begin
            stateNxt = ST_COLLECT;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      storeQ <= 1'b0;
    end else begin
      state  <= stateNxt;
      storeQ <= storeNow && !abortReq;
    end
  end

  assign storeEn = storeQ;
  assign convEn  = (state == ST_FILL) || (state == ST_MIDPOST) || (state == ST_COLLECT);
  assign acqDone = state == ST_DONE;

endmodule

// File: rtl/scan_acq_seq.sv
module scan_acq_seq
  import scan_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic [1:0]       modeSel,
  input  logic             mGuard,
  input  logic [CNT_W-1:0] mCount,
  input  logic [CNT_W-1:0] nCount,
  input  logic [DLY_W-1:0] delayCount,
  input  logic [CNT_W-1:0] retrigLimit,
  input  logic             scanDone,
  input  logic             convBusy,
  input  logic             trigIn,
  output logic             storeEn,
  output logic             convEn,
  output logic             acqDone,
  output logic [CNT_W:0]   storedCount,
  output logic [CNT_W:0]   postCount,
  output logic [CNT_W:0]   trigCount
);

  seqStrobe_t stb;
  logic fillFull;
  logic postLast;
  logic dlyLast;
  logic dlyZero;
  logic trigExhausted;

  scan_seq_ctrl ctrlInst (
    .clk           (clk),
    .rstN          (rstN),
    .startReq      (startReq),
    .abortReq      (abortReq),
    .mode          (acqMode_e'(modeSel)),
    .mGuard        (mGuard),
    .scanDone      (scanDone),
    .convBusy      (convBusy),
    .trigIn        (trigIn),
    .fillFull      (fillFull),
    .postLast      (postLast),
    .dlyLast       (dlyLast),
    .dlyZero       (dlyZero),
    .trigExhausted (trigExhausted),
    .stb           (stb),
    .storeEn       (storeEn),
    .convEn        (convEn),
    .acqDone       (acqDone)
  );

  scan_seq_dp #(.CNT_W(CNT_W), .DLY_W(DLY_W)) dpInst (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .mCount        (mCount),
    .nCount        (nCount),
    .delayCount    (delayCount),
    .retrigLimit   (retrigLimit),
    .fillFull      (fillFull),
    .postLast      (postLast),
    .dlyLast       (dlyLast),
    .dlyZero       (dlyZero),
    .trigExhausted (trigExhausted),
    .storedCount   (storedCount),
    .postCount     (postCount),
    .trigCount     (trigCount)
  );

endmodule

// File: rtl/scan_acq_seq_chk.sv
module scan_acq_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           abortReq,
  input logic [1:0]     modeSel,
  input logic           scanDone,
  input logic           storeEn,
  input logic           convEn,
  input logic           acqDone,
  input logic [CNT_W:0] storedCount,
  input logic [CNT_W:0] postCount
);

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!storeEn && !convEn && !acqDone));

  // R9
  store_follows_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeEn |-> $past(scanDone));

  // R9
  stored_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (storedCount != $past(storedCount)) |->
      ((storedCount == $past(storedCount) + 1'b1) || (storedCount == '0)));

  // R4
  pre_post_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0) |=> (postCount <= $past(postCount)));

  // R6
  done_no_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    acqDone |-> !convEn);

endmodule

bind scan_acq_seq scan_acq_seq_chk #(.CNT_W(CNT_W)) chkInst (.*);

// File: tb/scan_acq_seq_test.sv
`timescale 1ns/1ps
module scan_acq_seq_test;

  localparam int CNT_W = 16;
  localparam int DLY_W = 16;

  typedef struct packed {
    logic [1:0]  mode;
    logic        guard;
    logic [15:0] m;
    logic [15:0] n;
    logic [15:0] d;
    logic [15:0] r;
    logic [15:0] k1;
    logic [15:0] k2;
    logic [15:0] eStored;
    logic [15:0] ePost;
    logic [15:0] eTrig;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 16'd4, 16'd1, 16'd0, 16'd1, 16'd6, 16'd99, 16'd4, 16'd0, 16'd1},
    '{2'd0, 1'b0, 16'd5, 16'd1, 16'd0, 16'd1, 16'd1, 16'd99, 16'd2, 16'd0, 16'd1},
    '{2'd0, 1'b1, 16'd4, 16'd1, 16'd0, 16'd1, 16'd1, 16'd5,  16'd4, 16'd0, 16'd1},
    '{2'd1, 1'b0, 16'd3, 16'd2, 16'd0, 16'd1, 16'd5, 16'd99, 16'd5, 16'd2, 16'd1},
    '{2'd1, 1'b0, 16'd4, 16'd3, 16'd0, 16'd1, 16'd1, 16'd99, 16'd4, 16'd3, 16'd1},
    '{2'd1, 1'b1, 16'd4, 16'd2, 16'd0, 16'd1, 16'd2, 16'd6,  16'd6, 16'd2, 16'd1},
    '{2'd2, 1'b0, 16'd0, 16'd3, 16'd0, 16'd1, 16'd0, 16'd0,  16'd3, 16'd3, 16'd1},
    '{2'd2, 1'b0, 16'd0, 16'd2, 16'd0, 16'd3, 16'd0, 16'd0,  16'd6, 16'd2, 16'd3},
    '{2'd3, 1'b0, 16'd0, 16'd2, 16'd5, 16'd2, 16'd0, 16'd0,  16'd4, 16'd2, 16'd2},
    '{2'd3, 1'b0, 16'd0, 16'd4, 16'd0, 16'd1, 16'd0, 16'd0,  16'd4, 16'd4, 16'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic abortReq = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic mGuard = 1'b0;
  logic [CNT_W-1:0] mCount = '0;
  logic [CNT_W-1:0] nCount = 16'd1;
  logic [DLY_W-1:0] delayCount = '0;
  logic [CNT_W-1:0] retrigLimit = 16'd1;
  logic scanDone = 1'b0;
  logic convBusy = 1'b0;
  logic trigIn = 1'b0;
  logic storeEn;
  logic convEn;
  logic acqDone;
  logic [CNT_W:0] storedCount;
  logic [CNT_W:0] postCount;
  logic [CNT_W:0] trigCount;

  int checkCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  scan_acq_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .modeSel(modeSel), .mGuard(mGuard), .mCount(mCount), .nCount(nCount),
    .delayCount(delayCount), .retrigLimit(retrigLimit), .scanDone(scanDone),
    .convBusy(convBusy), .trigIn(trigIn), .storeEn(storeEn), .convEn(convEn),
    .acqDone(acqDone), .storedCount(storedCount), .postCount(postCount),
    .trigCount(trigCount)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  task automatic applyCfg(input vec_t v);
    modeSel = v.mode; mGuard = v.guard; mCount = v.m; nCount = v.n;
    delayCount = v.d; retrigLimit = v.r;
  endtask

  task automatic pulseAbort();
    @(negedge clk) abortReq = 1'b1;
    @(negedge clk) abortReq = 1'b0;
  endtask

  // scan model plus trigger driver, one negedge per iteration
  task automatic runVec(input vec_t v, input int maxCyc, output int doneSeen,
                        output int scans, output int pulses);
    int ph;
    bit p1;
    bit p2;
    applyCfg(v);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    ph = 0; p1 = 0; p2 = 0; scans = 0; pulses = 0; doneSeen = 0;
    for (int c = 0; c < maxCyc; c++) begin
      if (storeEn) pulses++;
      if (acqDone) begin
        doneSeen = 1;
        break;
      end
      trigIn = 1'b0;
      if (ph == 0) begin
        scanDone = 1'b0;
        if (convEn) begin
          convBusy = 1'b1;
          ph = 1;
        end
        if (!v.mode[1]) begin
          if (!p1 && scans == int'(v.k1)) begin
            trigIn = 1'b1; p1 = 1;
          end else if (!p2 && scans == int'(v.k2)) begin
            trigIn = 1'b1; p2 = 1;
          end
        end
      end else if (ph < 3) begin
        ph++;
      end else begin
        convBusy = 1'b0; scanDone = 1'b1; ph = 0; scans++;
      end
      if (v.mode[1] && !convEn) trigIn = 1'b1;
      @(negedge clk);
    end
    trigIn = 1'b0; scanDone = 1'b0; convBusy = 1'b0;
  endtask

  task automatic latency(input logic [1:0] md, input logic [15:0] dly, output int lat);
    vec_t v;
    v = '{md, 1'b0, 16'd0, 16'd2, dly, 16'd1, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0};
    applyCfg(v);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) begin startReq = 1'b0; trigIn = 1'b1; end
    lat = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk) trigIn = 1'b0;
      lat++;
      if (convEn) break;
    end
    pulseAbort();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL R1 watchdog expired: actual 150000 cycles expected completion");
    finishRun();
  end

  initial begin
    int doneSeen;
    int scans;
    int pulses;
    int lat;
    string tagMain;
    string tagTrig;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "convEn", convEn, 0);
    chk("R1", "storeEn", storeEn, 0);
    chk("R1", "acqDone", acqDone, 0);
    chk("R1", "storedCount", storedCount, 0);
    chk("R1", "trigCount", trigCount, 0);

    foreach (VECS[i]) begin
      runVec(VECS[i], 3000, doneSeen, scans, pulses);
      case (VECS[i].mode)
        2'd0: tagMain = "R2";
        2'd1: tagMain = "R5";
        2'd2: tagMain = "R6";
        default: tagMain = "R7";
      endcase
      if (VECS[i].guard) tagMain = "R3";
      tagTrig = VECS[i].guard ? "R3" : (i == 6) ? "R11" : "R8";
      chk(tagMain, $sformatf("vec%0d done", i), doneSeen, 1);
      chk(tagMain, $sformatf("vec%0d storedCount", i), storedCount, VECS[i].eStored);
      chk((VECS[i].mode == 2'd0) ? "R4" : tagMain, $sformatf("vec%0d postCount", i),
          postCount, VECS[i].ePost);
      chk(tagTrig, $sformatf("vec%0d trigCount", i), trigCount, VECS[i].eTrig);
      chk("R9", $sformatf("vec%0d store pulses", i), pulses, scans);
    end

    // R6 / R7 conversion enable latency after trigger
    latency(2'd2, 16'd0, lat);
    chk("R6", "post latency", lat, 1);
    latency(2'd3, 16'd5, lat);
    chk("R7", "delay latency", lat, 6);
    latency(2'd3, 16'd0, lat);
    chk("R7", "zero delay latency", lat, 1);

    // R8 unlimited re-trigger
    runVec('{2'd2, 1'b0, 16'd0, 16'd2, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
           400, doneSeen, scans, pulses);
    chk("R8", "unlimited done", doneSeen, 0);
    chk("R8", "unlimited trigCount>=3", (trigCount >= 3) ? 1 : 0, 1);
    pulseAbort();

    // R10 abort coincident with scan completion
    applyCfg('{2'd0, 1'b0, 16'd8, 16'd1, 16'd0, 16'd1, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0});
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    begin
      int ph = 0;
      int sc = 0;
      for (int c = 0; c < 200; c++) begin
        if (ph == 0) begin
          scanDone = 1'b0;
          if (convEn) begin convBusy = 1'b1; ph = 1; end
        end else if (ph < 3) begin
          ph++;
        end else begin
          convBusy = 1'b0; scanDone = 1'b1; ph = 0; sc++;
          if (sc == 3) begin
            abortReq = 1'b1;
            break;
          end
        end
        @(negedge clk);
      end
    end
    @(negedge clk) begin abortReq = 1'b0; scanDone = 1'b0; end
    chk("R10", "storeEn after abort", storeEn, 0);
    chk("R10", "convEn after abort", convEn, 0);
    chk("R10", "acqDone after abort", acqDone, 0);
    chk("R10", "storedCount after abort", storedCount, 2);
    trigIn = 1'b1;
    @(negedge clk) trigIn = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "idle convEn after trigger", convEn, 0);
    chk("R10", "idle trigCount after trigger", trigCount, 0);

    finishRun();
  end

endmodule